// File: doc/BRIEF.md
# PCM Highway Timeslot Port

This block places one sample per frame on a serial time-division highway and takes one sample back from it. It runs on the highway bit clock. Two bit-position counters restart at each frame sync. Each counter follows the sync timing chosen for its own direction, and each is compared with a free programmable start count. When the transmit count matches, the latched parallel sample is shifted out MSB first on the serial output. The output enable is asserted only for those bit periods. When the receive count matches, the serial input is shifted in, MSB first, and the completed word is presented in parallel with a one-cycle strobe.

The slot is given as a bit offset from the frame start, not as a slot number. One implementation therefore covers several highway formats: long or short sync, byte-aligned or offset slots, and back-to-back byte pairs. A start count that lies beyond the last bit of the frame silences that direction.

Top module: `pcm_slot_port`

## Requirements
- R1: With long sync (sync-mode input 0), bit period 0 is the period that begins at the first rising clock edge where frame sync is seen high. A direction whose start count is S sends or receives its MSB in bit period S, counted from that period.
- R2: With short sync (sync-mode input 1), bit period 0 begins one rising edge after the edge where frame sync is first seen high. The offset S is then counted from that period.
- R3: The transmit sample is sent MSB first, one bit per bit period. The serial output changes only on rising clock edges.
- R4: The transmit output enable is high exactly for the bit periods of the block's own sample and low at all other times, including before the first frame sync after reset.
- R5: When early release is 1, the output enable falls at the falling clock edge inside the LSB period. When early release is 0, it stays high until the rising edge that ends the LSB period.
- R6: When the wide-mode input is 1, both directions move 16 bits back to back starting at their start counts. The receive word then fills all 16 output bits.
- R7: The transmit sample is captured from the parallel input at the rising edge where frame sync is first seen high. Later changes on that input do not alter the bits sent in that frame.
- R8: The serial input is sampled on falling clock edges during the receive slot, MSB first. The word appears on the parallel output at the rising edge that ends the LSB period, together with a valid strobe that is high for exactly one cycle. The word is held until the next strobe. In 8-bit mode the upper 8 output bits are zero.
- R9: Transmit and receive use their own start counts and their own sync-mode inputs, and neither setting affects the other direction.
- R10: A start count larger than the number of bit periods between consecutive frame syncs never matches. The output enable then stays low and no valid strobe occurs.
- R11: During reset the output enable, the serial output, the valid strobe and the received word are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Highway bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync | input | 1 | Frame sync |
| tx_sync_short | input | 1 | Transmit sync mode: 1 short, 0 long |
| rx_sync_short | input | 1 | Receive sync mode: 1 short, 0 long |
| tx_early_release | input | 1 | 1 releases the output in the LSB falling half, 0 at the next rising edge |
| wide_mode | input | 1 | 1 selects 16-bit samples, 0 selects 8-bit |
| tx_start | input | START_W | Transmit start bit count |
| rx_start | input | START_W | Receive start bit count |
| tx_sample | input | 16 | Parallel sample to transmit |
| drx | input | 1 | Serial receive data |
| dtx | output | 1 | Serial transmit data |
| dtx_oe | output | 1 | Drive enable for dtx |
| rx_sample | output | 16 | Last received word |
| rx_valid | output | 1 | One-cycle strobe for a new rx_sample |

## Verification
The bench targets the edges of each slot. It checks the off-by-one between short and long sync, where a wrong design would send every bit one period early or late. It checks the output enable around the LSB under both release settings, where a wrong design would drive into the next slot or cut the LSB short. It changes the parallel transmit input just after sync, which exposes a design that reads it live instead of latching it. It also programs start counts past the frame length, where a design with a wrapping counter would transmit on the highway anyway.

// File: rtl/pcm_slot_pkg.sv
package pcm_slot_pkg;

   // sample geometry
   localparam int unsigned NARROW_BITS = 8;
   localparam int unsigned SAMPLE_W    = 16;
   localparam int unsigned LEN_W       = $clog2(SAMPLE_W) + 1;

   // number of bits moved per slot for the selected width mode
   function automatic logic [LEN_W-1:0] slot_len(input logic wide);
      return wide ? LEN_W'(SAMPLE_W) : LEN_W'(NARROW_BITS);
   endfunction

endpackage

// File: rtl/pcm_frame_counter.sv
module pcm_frame_counter #(
   parameter int CNT_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fsync,
   input  logic             short_mode,
   output logic [CNT_W-1:0] idx
);

   logic             fs_q;
   logic             rise_q;
   logic             rise;
   logic [CNT_W-1:0] cnt;

   assign rise = fsync & ~fs_q;

   // index of the bit period that starts at the current rising edge
   always_comb begin
      if (!short_mode && rise) begin
         idx = '0;
      end else if (short_mode && rise_q) begin
         idx = '0;
      end else if (cnt == '1) begin
         idx = cnt;
      end else begin
         idx = cnt + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fs_q   <= 1'b0;
         rise_q <= 1'b0;
         cnt    <= '1;
      end else begin
         fs_q   <= fsync;
         rise_q <= rise;
         cnt    <= idx;
      end
   end

endmodule

// File: rtl/pcm_slot_window.sv
module pcm_slot_window #(
   parameter int LEN_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [LEN_W-1:0] len,
   output logic             active,
   output logic             last
);

   logic [LEN_W-1:0] remain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         last   <= 1'b0;
         remain <= '0;
      end else if (start) begin
         active <= 1'b1;
         last   <= 1'b0;
         remain <= len - 1'b1;
      end else if (active) begin
         if (remain == '0) begin
            active <= 1'b0;
            last   <= 1'b0;
         end else begin
            remain <= remain - 1'b1;
            last   <= (remain == LEN_W'(1));
         end
      end
   end

endmodule

// File: rtl/pcm_tx_lane.sv
module pcm_tx_lane
   import pcm_slot_pkg::*;
#(
   parameter int W = SAMPLE_W
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic         wide,
   input  logic         early,
   input  logic [W-1:0] sample,
   output logic         dtx,
   output logic         dtx_oe
);

   localparam int PAD = W - NARROW_BITS;

   logic         active;
   logic         last;
   logic         lsb_half;
   logic [W-1:0] sreg;

   pcm_slot_window #(.LEN_W(LEN_W)) u_win (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (start),
      .len    (slot_len(wide)),
      .active (active),
      .last   (last)
   );

   // launch on rising edges, MSB first
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sreg <= '0;
      end else if (start) begin
         sreg <= wide ? sample : (sample << PAD);
      end else if (active) begin
         sreg <= sreg << 1;
      end
   end

   // marks the low half of the LSB period
   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lsb_half <= 1'b0;
      end else begin
         lsb_half <= active & last;
      end
   end

   assign dtx    = active & sreg[W-1];
   assign dtx_oe = active & ~(early & last & lsb_half);

endmodule

// File: rtl/pcm_rx_lane.sv
module pcm_rx_lane
   import pcm_slot_pkg::*;
#(
   parameter int W = SAMPLE_W
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic         wide,
   input  logic         drx,
   output logic [W-1:0] rx_data,
   output logic         rx_valid
);

   localparam int PAD = W - NARROW_BITS;

   logic         active;
   logic         last;
   logic         fin;
   logic [W-1:0] rsh;

   pcm_slot_window #(.LEN_W(LEN_W)) u_win (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (start),
      .len    (slot_len(wide)),
      .active (active),
      .last   (last)
   );

   // capture in the middle of each bit period
   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsh <= '0;
         fin <= 1'b0;
      end else begin
         fin <= active & last;
         if (active) begin
            rsh <= {rsh[W-2:0], drx};
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_valid <= 1'b0;
         rx_data  <= '0;
      end else begin
         rx_valid <= fin;
         if (fin) begin
            rx_data <= wide ? rsh : {{PAD{1'b0}}, rsh[NARROW_BITS-1:0]};
         end
      end
   end

endmodule

// File: rtl/pcm_slot_port.sv
module pcm_slot_port
   import pcm_slot_pkg::*;
#(
   parameter  int SLOT_MAX = 128,
   localparam int START_W  = $clog2(SLOT_MAX * NARROW_BITS),
   localparam int CNT_W    = START_W + 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                fsync,
   input  logic                tx_sync_short,
   input  logic                rx_sync_short,
   input  logic                tx_early_release,
   input  logic                wide_mode,
   input  logic [START_W-1:0]  tx_start,
   input  logic [START_W-1:0]  rx_start,
   input  logic [SAMPLE_W-1:0] tx_sample,
   input  logic                drx,
   output logic                dtx,
   output logic                dtx_oe,
   output logic [SAMPLE_W-1:0] rx_sample,
   output logic                rx_valid
);

   localparam int NDIR = 2;

   // elaboration-time parameter checks
   if (SLOT_MAX < 4 || SLOT_MAX > 128) begin : g_bad_range
      $error("SLOT_MAX must lie between 4 and 128");
   end
   if ((SLOT_MAX & (SLOT_MAX - 1)) != 0) begin : g_bad_pow2
      $error("SLOT_MAX must be a power of two");
   end

   logic [NDIR-1:0]  dir_short;
   logic [CNT_W-1:0] dir_idx [NDIR];
   logic [CNT_W-1:0] tx_idx;
   logic [CNT_W-1:0] rx_idx;

   assign dir_short = {rx_sync_short, tx_sync_short};

   // one bit-position counter per direction, each with its own sync timing
   for (genvar d = 0; d < NDIR; d++) begin : g_dir
      pcm_frame_counter #(.CNT_W(CNT_W)) u_cnt (
         .clk        (clk),
         .rst_n      (rst_n),
         .fsync      (fsync),
         .short_mode (dir_short[d]),
         .idx        (dir_idx[d])
      );
   end

   assign tx_idx = dir_idx[0];
   assign rx_idx = dir_idx[1];

   logic tx_go;
   logic rx_go;

   assign tx_go = (tx_idx == {1'b0, tx_start});
   assign rx_go = (rx_idx == {1'b0, rx_start});

   // transmit sample captured at the sync edge, bypassed on that same edge
   logic                fs_q;
   logic                sync_edge;
   logic [SAMPLE_W-1:0] tx_hold;
   logic [SAMPLE_W-1:0] tx_src;

   assign sync_edge = fsync & ~fs_q;
   assign tx_src    = sync_edge ? tx_sample : tx_hold;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fs_q    <= 1'b0;
         tx_hold <= '0;
      end else begin
         fs_q <= fsync;
         if (sync_edge) begin
            tx_hold <= tx_sample;
         end
      end
   end

   pcm_tx_lane #(.W(SAMPLE_W)) u_tx (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (tx_go),
      .wide   (wide_mode),
      .early  (tx_early_release),
      .sample (tx_src),
      .dtx    (dtx),
      .dtx_oe (dtx_oe)
   );

   pcm_rx_lane #(.W(SAMPLE_W)) u_rx (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (rx_go),
      .wide     (wide_mode),
      .drx      (drx),
      .rx_data  (rx_sample),
      .rx_valid (rx_valid)
   );

endmodule

// File: rtl/pcm_slot_port_chk.sv
module pcm_slot_port_chk #(
   parameter int START_W = 10,
   parameter int CNT_W   = 11
) (
   input logic               clk,
   input logic               rst_n,
   input logic               fsync,
   input logic               tx_sync_short,
   input logic               wide_mode,
   input logic [START_W-1:0] tx_start,
   input logic               dtx_oe,
   input logic               rx_valid,
   input logic [15:0]        rx_sample,
   input logic [CNT_W-1:0]   tx_idx
);

   logic fs_seen;
   logic rose_seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fs_seen   <= 1'b0;
         rose_seen <= 1'b0;
      end else begin
         fs_seen   <= fsync;
         rose_seen <= fsync & ~fs_seen;
      end
   end

   AST_LONG_SYNC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (fsync && !fs_seen && !tx_sync_short) |-> (tx_idx == '0)); // R1

   AST_SHORT_SYNC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rose_seen && tx_sync_short) |-> (tx_idx == '0)); // R2

   AST_OE_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dtx_oe) |-> ($past(tx_idx) == {1'b0, $past(tx_start)})); // R1

   AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid); // R8

   AST_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_valid |-> $stable(rx_sample)); // R8

   AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && !$past(wide_mode)) |-> (rx_sample[15:8] == 8'h00)); // R8

endmodule

bind pcm_slot_port pcm_slot_port_chk #(.START_W(START_W), .CNT_W(CNT_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .fsync         (fsync),
   .tx_sync_short (tx_sync_short),
   .wide_mode     (wide_mode),
   .tx_start      (tx_start),
   .dtx_oe        (dtx_oe),
   .rx_valid      (rx_valid),
   .rx_sample     (rx_sample),
   .tx_idx        (tx_idx)
);

// File: tb/pcm_slot_port_test.sv
module pcm_slot_port_test;

   localparam int START_W = 10;

   logic               clk = 1'b0;
   logic               rst_n;
   logic               fsync;
   logic               tx_sync_short;
   logic               rx_sync_short;
   logic               tx_early_release;
   logic               wide_mode;
   logic [START_W-1:0] tx_start;
   logic [START_W-1:0] rx_start;
   logic [15:0]        tx_sample;
   logic               drx;
   logic               dtx;
   logic               dtx_oe;
   logic [15:0]        rx_sample;
   logic               rx_valid;

   int errors = 0;
   int checks = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   pcm_slot_port uut (
      .clk              (clk),
      .rst_n            (rst_n),
      .fsync            (fsync),
      .tx_sync_short    (tx_sync_short),
      .rx_sync_short    (rx_sync_short),
      .tx_early_release (tx_early_release),
      .wide_mode        (wide_mode),
      .tx_start         (tx_start),
      .rx_start         (rx_start),
      .tx_sample        (tx_sample),
      .drx              (drx),
      .dtx              (dtx),
      .dtx_oe           (dtx_oe),
      .rx_sample        (rx_sample),
      .rx_valid         (rx_valid)
   );

   task automatic check(string req, string what, logic [15:0] act, logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
      end
   endtask

   // R11: quiet outputs while held in reset
   task automatic test_reset();
      rst_n = 1'b0; fsync = 1'b0; drx = 1'b1;
      tx_sync_short = 1'b0; rx_sync_short = 1'b0; tx_early_release = 1'b0;
      wide_mode = 1'b0; tx_start = '1; rx_start = '1; tx_sample = 16'hFFFF;
      repeat (3) @(posedge clk);
      #5;
      check("R11", "dtx_oe in reset", dtx_oe, 0);
      check("R11", "dtx in reset", dtx, 0);
      check("R11", "rx_valid in reset", rx_valid, 0);
      check("R11", "rx_sample in reset", rx_sample, 16'h0000);
      @(posedge clk); #5;
      rst_n = 1'b1;
      repeat (3) begin
         @(posedge clk); #5;
         check("R4", "dtx_oe before first sync", dtx_oe, 0);
      end
   endtask

   // one frame: transmit and receive slots checked bit by bit
   task automatic run_frame(bit tshort, bit rshort, bit early, bit wide,
                            int ts, int rs, logic [15:0] tval, logic [15:0] rval);
      int n;
      int jmax;
      int toff;
      int roff;
      string ttag;
      string rtag;
      logic [15:0] rexp;
      n    = wide ? 16 : 8;
      toff = tshort ? 1 : 0;
      roff = rshort ? 1 : 0;
      jmax = ((toff + ts) > (roff + rs) ? (toff + ts) : (roff + rs)) + n + 2;
      ttag = {tshort ? "R2" : "R1", " R3 R7", wide ? " R6" : ""};
      rtag = {rshort ? "R2" : "R1", " R8 R9", wide ? " R6" : ""};
      rexp = wide ? rval : {8'h00, rval[7:0]};
      @(posedge clk); #5;
      tx_sync_short = tshort; rx_sync_short = rshort;
      tx_early_release = early; wide_mode = wide;
      tx_start = START_W'(ts); rx_start = START_W'(rs);
      tx_sample = tval; fsync = 1'b1;
      for (int j = 0; j <= jmax; j++) begin
         int ti;
         int ri;
         @(posedge clk); #5;
         if (j == 0) begin
            fsync = 1'b0;
            tx_sample = ~tval;  // must not reach the wire this frame (R7)
         end
         ti = j - toff - ts;
         ri = j - roff - rs;
         if (ti >= 0 && ti < n) begin
            check("R4", "dtx_oe in slot", dtx_oe, 1);
            check(ttag, "dtx bit", dtx, tval[n-1-ti]);
         end else begin
            check("R4", "dtx_oe outside slot", dtx_oe, 0);
         end
         drx = (ri >= 0 && ri < n) ? rval[n-1-ri] : 1'b1;
         if (ri == n) begin
            check(rtag, "rx_valid strobe", rx_valid, 1);
            check(rtag, "rx_sample word", rx_sample, rexp);
         end else begin
            check("R8", "rx_valid idle", rx_valid, 0);
            if (ri == n + 1) check("R8", "rx_sample held", rx_sample, rexp);
         end
         #10;
         if (ti == n - 1) check("R5", "dtx_oe in LSB low half", dtx_oe, early ? 0 : 1);
      end
   endtask

   // R10: start counts beyond a 32-bit frame never fire
   task automatic test_far_start();
      @(posedge clk); #5;
      tx_sync_short = 1'b0; rx_sync_short = 1'b0; wide_mode = 1'b0;
      tx_start = START_W'(40); rx_start = START_W'(36);
      fsync = 1'b1;
      for (int f = 0; f < 3; f++) begin
         int bad_oe;
         int bad_valid;
         bad_oe = 0;
         bad_valid = 0;
         for (int j = 0; j < 32; j++) begin
            @(posedge clk); #5;
            if (j == 0) fsync = 1'b0;
            if (j == 31) fsync = 1'b1;
            if (dtx_oe !== 1'b0) bad_oe++;
            if (rx_valid !== 1'b0) bad_valid++;
         end
         check("R10", "dtx_oe high samples in short frame", 16'(bad_oe), 0);
         check("R10", "rx_valid strobes in short frame", 16'(bad_valid), 0);
      end
      fsync = 1'b0;
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual running expected finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      test_reset();
      run_frame(1'b0, 1'b0, 1'b0, 1'b0,   0,  5, 16'h00A5, 16'h003C);
      run_frame(1'b1, 1'b0, 1'b1, 1'b0,   3,  0, 16'h0081, 16'h007E);
      run_frame(1'b1, 1'b1, 1'b0, 1'b1,  10, 40, 16'hC3A5, 16'h5A0F);
      run_frame(1'b0, 1'b0, 1'b1, 1'b1, 100,  7, 16'h96E1, 16'h1F80);
      run_frame(1'b1, 1'b1, 1'b1, 1'b0,   0,  0, 16'h0001, 16'hAB80);
      run_frame(1'b0, 1'b1, 1'b0, 1'b0,  24,  2, 16'h00FF, 16'hFF00);
      test_far_start();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule